// File: doc/BRIEF.md
# Vectored Interrupt Controller with Memory-Mapped Registers

This block gathers a configurable number of interrupt inputs (up to 32) into a latched status word. It qualifies that word with a per-input enable word and raises a single request line towards a processor. Each input is fixed at build time as edge-triggered or level-triggered by a kind mask parameter.

Software works with the block through a small synchronous register port: a byte address, 32-bit write data, a write strobe and a registered read-data bus. Through that port it can:
- replace the enable word, or set or clear single enable bits without a read-modify-write;
- clear latched requests with a write-one-to-clear acknowledge;
- read the number of the lowest pending input;
- gate the request line with a two-bit master control.

A typical handler reads the vector, services that source, and acknowledges its bit.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), status, enable and master control are all zero, `rdata_o` is 0 and `irq_o` is 0.
- R2: Registers are selected by `addr_i[4:2]` when `addr_i[1:0]` is 00: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. `rdata_o` holds the value of the register addressed in the previous cycle. Acknowledge, set-enable and clear-enable read as 0. An address with `addr_i[1:0]` not 00 reads 0 and ignores writes.
- R3: A write to the enable register replaces the whole enable word, so writing 0 disables every input at once.
- R4: A write to set-enable sets each enable bit whose data bit is 1 and leaves the others unchanged.
- R5: A write to clear-enable clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R6: A write to acknowledge clears each status bit whose data bit is 1. Writing all ones clears every latched request that has no new event in that cycle.
- R7: An edge input (kind bit 1) sets its status bit on a rising edge, taken against a registered copy of the input. The bit stays set until acknowledged. A rising edge in the same cycle as its acknowledge leaves the bit set.
- R8: A level input (kind bit 0) sets its status bit in every cycle in which it is high and keeps it until acknowledged. An acknowledge while the input is still high clears the bit for that edge, and the bit is set again at the next edge.
- R9: The pending register reads status AND enable. Bits at and above the input count read 0.
- R10: The vector register reads the index of the lowest-numbered pending input, or 0xFFFFFFFF when nothing is pending.
- R11: The master register holds data bits [1:0] (bit 0 master enable, bit 1 hardware request enable) and reads back zero-extended. `irq_o` is 1 in the cycle after one in which both bits are set and at least one input is pending, and 0 otherwise.
- R12: Writes to the status, pending and vector registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt inputs |
| addr_i | input | 5 | Byte address of the register port |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with six inputs and kind mask 6'b110010, so inputs 1, 4 and 5 are edge-triggered and 0, 2 and 3 are level-triggered. Both latch styles can then be driven, acknowledged and compared side by side within a short run. The narrow width puts bits above the input count in reach for the pending and enable read-back. It also lets a full acknowledge and the empty-vector value be exercised with a handful of writes.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;

  localparam logic [DATA_W-1:0] NO_VECTOR = '1;
  localparam logic [1:0] MASTER_ON = 2'b11;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] KIND_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (KIND_MASK[g]) begin : g_edge
      logic src_q;
      logic rise;
      assign rise = src_i[g] & ~src_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          src_q       <= 1'b0;
          status_o[g] <= 1'b0;
        end else begin
          src_q <= src_i[g];
          if (rise)          status_o[g] <= 1'b1;
          else if (ack_i[g]) status_o[g] <= 1'b0;
        end
      end
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (rst)           status_o[g] <= 1'b0;
        else if (ack_i[g]) status_o[g] <= 1'b0;
        else if (src_i[g]) status_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] KIND_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [1:0]         mer_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] ack_vec;
  logic [NUM_SRC-1:0] wbits;
  logic               aligned;
  reg_sel_e           sel;
  logic               found;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  rd_next;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign sel     = reg_sel_e'(addr_i[4:2]);
  assign wbits   = wdata_i[NUM_SRC-1:0];
  assign ack_vec = (wr_i && aligned && sel == SEL_ACK) ? wbits : '0;
  assign pend    = status_q & enable_q;

  irq_src_latch #(.NUM_SRC(NUM_SRC), .KIND_MASK(KIND_MASK)) u_latch (
    .clk(clk), .rst(rst), .src_i(src_i), .ack_i(ack_vec), .status_o(status_q)
  );

  irq_lowest_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend_i(pend), .found_o(found), .idx_o(idx)
  );

  // Control registers written through the port
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      mer_q    <= 2'b00;
    end else if (wr_i && aligned) begin
      case (sel)
        SEL_ENABLE: enable_q <= wbits;
        SEL_SETEN:  enable_q <= enable_q | wbits;
        SEL_CLREN:  enable_q <= enable_q & ~wbits;
        SEL_MASTER: mer_q    <= wdata_i[1:0];
        default:    ;
      endcase
    end
  end

  // Read mux, registered
  always_comb begin
    rd_next = '0;
    if (aligned) begin
      case (sel)
        SEL_STATUS: rd_next = DATA_W'(status_q);
        SEL_PEND:   rd_next = DATA_W'(pend);
        SEL_ENABLE: rd_next = DATA_W'(enable_q);
        SEL_VECTOR: rd_next = found ? DATA_W'(idx) : NO_VECTOR;
        SEL_MASTER: rd_next = DATA_W'(mer_q);
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      rdata_o <= rd_next;
      irq_o   <= (|pend) && (mer_q == MASTER_ON);
    end
  end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] KIND_MASK = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               wr_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] enable_q,
  input logic [1:0]         mer_q
);
  localparam logic [ADDR_W-1:0] A_ENABLE = 5'h08;
  localparam logic [ADDR_W-1:0] A_ACK    = 5'h0C;
  localparam logic [ADDR_W-1:0] A_SETEN  = 5'h10;
  localparam logic [ADDR_W-1:0] A_CLREN  = 5'h14;

  AST_ENABLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_ENABLE && wdata_i == '0) |=> (enable_q == '0)); // R3
  AST_SETEN_ONES: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_SETEN) |=>
      ((enable_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0]))); // R4
  AST_CLREN_ONES: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_CLREN) |=>
      ((enable_q & $past(wdata_i[NUM_SRC-1:0])) == '0)); // R5
  AST_ACK_LEVEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_ACK) |=>
      ((status_q & $past(wdata_i[NUM_SRC-1:0]) & ~KIND_MASK) == '0)); // R8
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && addr_i == A_ACK) |=>
      (($past(status_q) & KIND_MASK & ~status_q) == '0)); // R7
  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(mer_q) == MASTER_ON)); // R11
  AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (rst)
    (mer_q == MASTER_ON && (status_q & enable_q) != '0) |=> irq_o); // R11
endmodule

bind irq_vec_ctrl irq_vec_chk #(.NUM_SRC(NUM_SRC), .KIND_MASK(KIND_MASK)) u_chk (
  .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i),
  .irq_o(irq_o), .status_q(status_q), .enable_q(enable_q), .mer_q(mer_q)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  localparam int N = 6;
  localparam logic [N-1:0] KIND = 6'b110010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl #(.NUM_SRC(N), .KIND_MASK(KIND)) dut (
    .clk(clk), .rst(rst), .src_i(src), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rdata_o(rdata), .irq_o(irq)
  );

  // Behavioural reference model
  logic [N-1:0] m_st, m_en, m_srcq;
  logic [1:0]   m_mer;
  logic [31:0]  m_rd;
  logic         m_irq;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [N-1:0] p;
    p = m_st & m_en;
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return 32'(m_st);
      3'd1: return 32'(p);
      3'd2: return 32'(m_en);
      3'd6: begin
        for (int i = 0; i < N; i++) if (p[i]) return i;
        return 32'hFFFF_FFFF;
      end
      3'd7: return 32'(m_mer);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_st = '0; m_en = '0; m_srcq = '0; m_mer = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      logic wok;
      m_rd  = m_read(addr);
      m_irq = ((m_st & m_en) != '0) && (m_mer == 2'b11);
      wok   = wr && (addr[1:0] == 2'b00);
      for (int i = 0; i < N; i++) begin
        logic ackb;
        ackb = wok && addr[4:2] == 3'd3 && wdata[i];
        if (KIND[i]) begin
          if (src[i] && !m_srcq[i]) m_st[i] = 1'b1;
          else if (ackb)            m_st[i] = 1'b0;
        end else begin
          if (ackb)        m_st[i] = 1'b0;
          else if (src[i]) m_st[i] = 1'b1;
        end
      end
      m_srcq = src;
      if (wok) begin
        case (addr[4:2])
          3'd2: m_en = wdata[N-1:0];
          3'd4: m_en = m_en | wdata[N-1:0];
          3'd5: m_en = m_en & ~wdata[N-1:0];
          3'd7: m_mer = wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      n_chk++;
      if (rdata !== m_rd || irq !== m_irq) begin
        n_fail++;
        $display("FAIL R2 R9 R10 R11 cycle model: rdata=%h irq=%b expected rdata=%h irq=%b",
                 rdata, irq, m_rd, m_irq);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    addr = a; wr = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic set_src(input logic [N-1:0] s);
    @(negedge clk); #1;
    src = s; wr = 1'b0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd_reg(5'h00, v); check("R1 status", v, 0);
    rd_reg(5'h08, v); check("R1 enable", v, 0);
    rd_reg(5'h1C, v); check("R1 master", v, 0);
    check("R1 irq", 32'(irq), 0);
    rd_reg(5'h18, v); check("R10 empty vector", v, 32'hFFFF_FFFF);
    // R8 level latch, R9 pending gating
    set_src(6'b000001);
    rd_reg(5'h00, v); check("R8 level sets", v, 32'h1);
    rd_reg(5'h04, v); check("R9 pending masked", v, 0);
    wr_reg(5'h08, 32'hFFFF_FFFF);
    rd_reg(5'h08, v); check("R9 enable upper bits", v, 32'h3F);
    rd_reg(5'h04, v); check("R9 pending", v, 32'h1);
    rd_reg(5'h18, v); check("R10 vector 0", v, 0);
    // R11 master gating
    check("R11 irq off", 32'(irq), 0);
    wr_reg(5'h1C, 32'h1);
    repeat (2) @(negedge clk);
    check("R11 irq one bit", 32'(irq), 0);
    wr_reg(5'h1C, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check("R11 irq on", 32'(irq), 1);
    rd_reg(5'h1C, v); check("R11 master read", v, 3);
    // R5, R4
    wr_reg(5'h14, 32'h1);
    rd_reg(5'h08, v); check("R5 clear-enable", v, 32'h3E);
    wr_reg(5'h10, 32'h1);
    rd_reg(5'h08, v); check("R4 set-enable", v, 32'h3F);
    // R8 ack while high
    wr_reg(5'h0C, 32'h1);
    rd_reg(5'h00, v); check("R8 ack clears", v, 0);
    rd_reg(5'h00, v); check("R8 re-set", v, 32'h1);
    set_src(6'b000000);
    rd_reg(5'h00, v); check("R8 sticky", v, 32'h1);
    wr_reg(5'h0C, 32'h1);
    rd_reg(5'h00, v); check("R6 ack", v, 0);
    repeat (2) @(negedge clk);
    check("R11 irq drops", 32'(irq), 0);
    // R7 edge input 1
    set_src(6'b000010);
    rd_reg(5'h00, v); check("R7 edge sets", v, 32'h2);
    wr_reg(5'h0C, 32'h2);
    rd_reg(5'h00, v); check("R7 ack while high", v, 0);
    rd_reg(5'h00, v); check("R7 no re-set", v, 0);
    set_src(6'b000000);
    set_src(6'b000010);
    set_src(6'b000000);
    rd_reg(5'h00, v); check("R7 held after drop", v, 32'h2);
    // R10 lowest pick
    set_src(6'b010100);
    rd_reg(5'h18, v); check("R10 lowest", v, 1);
    wr_reg(5'h0C, 32'h2);
    rd_reg(5'h18, v); check("R10 vector 2", v, 2);
    wr_reg(5'h14, 32'h4);
    rd_reg(5'h18, v); check("R10 vector 4", v, 4);
    // R12 read-only registers
    rd_reg(5'h00, v);
    wr_reg(5'h00, 32'h0);
    wr_reg(5'h04, 32'h0);
    wr_reg(5'h18, 32'h0);
    rd_reg(5'h00, 32'h0 == 0 ? v : v);
    check("R12 status kept", v, 32'h14);
    // R2 misaligned access
    wr_reg(5'h09, 32'h0);
    rd_reg(5'h08, v); check("R2 misaligned write", v, 32'h3B);
    rd_reg(5'h09, v); check("R2 misaligned read", v, 0);
    rd_reg(5'h10, v); check("R2 set-enable reads 0", v, 0);
    // R3 disable all
    wr_reg(5'h08, 32'h0);
    rd_reg(5'h04, v); check("R3 pending none", v, 0);
    rd_reg(5'h18, v); check("R10 none", v, 32'hFFFF_FFFF);
    check("R3 irq off", 32'(irq), 0);
    // R6 acknowledge all
    set_src(6'b000000);
    wr_reg(5'h0C, 32'hFFFF_FFFF);
    rd_reg(5'h00, v); check("R6 all cleared", v, 0);
    // R1 reset again mid-run
    wr_reg(5'h08, 32'h3F);
    @(negedge clk); #1 rst = 1'b1; wr = 1'b0;
    @(negedge clk); #1 rst = 1'b0;
    rd_reg(5'h08, v); check("R1 reset clears enable", v, 0);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule